// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-line general-purpose I/O port on a simple byte-wide register bus. Each pin can be an input or an output, chosen by a direction register. Output pins are driven from an output register. Input pins are sampled through a two-stage synchronizer before software can see them.

The data register is reached through a window of addresses rather than a single offset. Address bits [9:2] of a data access form a per-pin mask. A write changes only the pins whose mask bit is set, so software can change one pin without reading the register first. A read returns only the masked pins and returns zero in every other bit. The direction register sits just above the data window. All other offsets above the window read as zero and ignore writes.

The bus is a plain strobe interface. A write takes effect on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational from the address while `bus_en` is high and `bus_we` is low.

Top module: `gpio_masked_port`

## Requirements
- R1: While `rst` is high and on the cycle after it, every pin is an input (`pad_oe` = 0x00), the output register is clear (`pad_out` = 0x00), and the synchronized inputs read as zero.
- R2: A write to a data offset (address bit 10 = 0) loads `bus_wdata` bit n into output bit n only when address bit (n+2) is set and pin n is an output. Every other output bit keeps its value. Address bits [1:0] are ignored.
- R3: A data write to a pin that is an input at that moment leaves that pin's output register bit unchanged. After the pin becomes an output, it drives its previous value until it is written again.
- R4: A write to offset 0x400 loads the direction register from the next edge: bit n = 1 makes pin n an output. `pad_oe` mirrors the direction register, and a read of 0x400 returns it.
- R5: A data read returns, in bit n with address bit (n+2) set, the output register bit if pin n is an output, or else the synchronized pad bit. Bits whose mask bit is clear read as 0.
- R6: A change on `pad_in` becomes visible to a data read after exactly two rising clock edges, not one.
- R7: Offsets with bit 10 set, other than 0x400, read as 0x00, and writes to them change neither register.
- R8: With `bus_en` low, no register changes, whatever `bus_we`, `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Raw pad inputs |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |

## Verification
The hardest case to reach is a pin that received a data write while it was an input and then becomes an output. This shows whether the write was dropped (R3) rather than stored. The bench writes all-ones while the upper pins are inputs, then switches them to outputs. It checks that `pad_out` still shows zeros until a fresh write lands. Synchronizer latency is measured by changing `pad_in` while the address is held steady, then reading after one edge and again after two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int LINES    = 8;
    localparam int MASK_LSB = 2;
    localparam int AW       = LINES + MASK_LSB + 1;

    typedef logic [LINES-1:0] pins_t;
    typedef logic [AW-1:0]    addr_t;

    localparam addr_t DIR_OFFSET = {1'b1, {(AW-1){1'b0}}};

    typedef enum logic [1:0] {
        ACC_DATA = 2'd0,
        ACC_DIR  = 2'd1,
        ACC_NONE = 2'd2
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t kind;
        pins_t     mask;
    } acc_dec_t;

    function automatic acc_dec_t decode_addr(input addr_t a);
        acc_dec_t d;
        if (!a[AW-1]) begin
            d.kind = ACC_DATA;
            d.mask = a[LINES+MASK_LSB-1:MASK_LSB];
        end else if (a == DIR_OFFSET) begin
            d.kind = ACC_DIR;
            d.mask = '1;
        end else begin
            d.kind = ACC_NONE;
            d.mask = '0;
        end
        return d;
    endfunction

    function automatic pins_t merge_bits(input pins_t old_v, input pins_t new_v,
                                         input pins_t en);
        return (old_v & ~en) | (new_v & en);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = gpio_port_pkg::LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= din[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign dout = stage2_q;

    // edges seen since reset, saturating at two
    logic [1:0] settle_q;
    always_ff @(posedge clk) begin
        if (rst)                 settle_q <= 2'd0;
        else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
    end

    assert_sync_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (settle_q == 2'd2) |-> (dout == $past(din, 2)));

    assert_sync_reset_R1: assert property (@(posedge clk)
        rst |=> (dout == '0));

endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
(
    input  logic      bus_en,
    input  logic      bus_we,
    input  addr_t     bus_addr,
    output acc_dec_t  dec,
    output logic      data_wr,
    output logic      dir_wr,
    output logic      rd_en
);
    always_comb begin
        dec     = decode_addr(bus_addr);
        data_wr = bus_en && bus_we && (dec.kind == ACC_DATA);
        dir_wr  = bus_en && bus_we && (dec.kind == ACC_DIR);
        rd_en   = bus_en && !bus_we;
    end
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_port_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  data_wr,
    input  logic  dir_wr,
    input  pins_t mask,
    input  pins_t wdata,
    output pins_t dir_q,
    output pins_t out_q
);
    pins_t out_en;

    always_comb out_en = mask & dir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else begin
            if (dir_wr)  dir_q <= wdata;
            if (data_wr) out_q <= merge_bits(out_q, wdata, out_en);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dir_q == '0 && out_q == '0));

    assert_unmasked_hold_R2: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0));

    assert_input_pin_hold_R3: assert property (@(posedge clk) disable iff (rst)
        data_wr |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0));

    assert_dir_load_R4: assert property (@(posedge clk) disable iff (rst)
        dir_wr |=> (dir_q == $past(wdata)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!data_wr && !dir_wr) |=> ($stable(out_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_port_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    pad_in,
    output logic [7:0]    pad_out,
    output logic [7:0]    pad_oe
);
    acc_dec_t dec;
    logic     data_wr;
    logic     dir_wr;
    logic     rd_en;
    pins_t    dir_q;
    pins_t    out_q;
    pins_t    pin_sync;
    pins_t    pin_view;

    gpio_bus_decode u_dec (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .dec      (dec),
        .data_wr  (data_wr),
        .dir_wr   (dir_wr),
        .rd_en    (rd_en)
    );

    gpio_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .data_wr (data_wr),
        .dir_wr  (dir_wr),
        .mask    (dec.mask),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .out_q   (out_q)
    );

    gpio_in_sync #(.WIDTH(LINES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pin_sync)
    );

    always_comb begin
        pin_view = (dir_q & out_q) | (~dir_q & pin_sync);
        if (!rd_en) begin
            bus_rdata = '0;
        end else begin
            unique case (dec.kind)
                ACC_DATA: bus_rdata = pin_view & dec.mask;
                ACC_DIR:  bus_rdata = dir_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    assert_read_unmasked_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !bus_addr[AW-1]) |-> ((bus_rdata & ~bus_addr[LINES+MASK_LSB-1:MASK_LSB]) == '0));

    assert_hole_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_addr[AW-1] && bus_addr != DIR_OFFSET) |-> (bus_rdata == '0));

    assert_oe_follows_dir_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && bus_addr == DIR_OFFSET) |-> (bus_rdata == pad_oe));

endmodule

// File: tb/tb_gpio_masked_port.sv
module tb_gpio_masked_port;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_en;
    logic        bus_we;
    logic [10:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [7:0]  pad_in;
    logic [7:0]  pad_out;
    logic [7:0]  pad_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    gpio_masked_port dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // {write, addr, data-or-expected}; pad_in held at 0xA5
    localparam int NVEC = 16;
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b1, 11'h400, 8'h0F},  // R4 low nibble outputs
        {1'b1, 11'h3FC, 8'hFF},  // R2 full mask, upper are inputs
        {1'b0, 11'h3FC, 8'hAF},  // R5 mixed view
        {1'b1, 11'h008, 8'h00},  // R2 pin1 alone
        {1'b0, 11'h3FC, 8'hAD},  // R2 others kept
        {1'b0, 11'h008, 8'h00},  // R5 pin1 alone
        {1'b0, 11'h004, 8'h01},  // R5 pin0 alone
        {1'b0, 11'h200, 8'h80},  // R5 input pin7 alone
        {1'b0, 11'h400, 8'h0F},  // R4 direction read
        {1'b1, 11'h404, 8'hFF},  // R7 hole write
        {1'b0, 11'h404, 8'h00},  // R7 hole read
        {1'b0, 11'h400, 8'h0F},  // R7 direction untouched
        {1'b1, 11'h030, 8'h00},  // R2 pins 2 and 3
        {1'b0, 11'h3FC, 8'hA1},  // R2
        {1'b1, 11'h3FF, 8'hFE},  // R2 low address bits ignored
        {1'b0, 11'h3FC, 8'hAE}   // R2
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19]) begin
                do_write(VEC[i][18:8], VEC[i][7:0]);
            end else begin
                do_read(VEC[i][18:8], rd);
                check($sformatf("R2/R4/R5/R7 vector %0d", i), rd, VEC[i][7:0]);
            end
        end

        check("R4 pad_oe mirrors direction", pad_oe, 8'h0F);
        check("R2 pad_out", pad_out, 8'h0E);

        // R3: write to input pins is dropped
        do_write(11'h3FC, 8'hF0);
        check("R3 pad_out after write", pad_out, 8'h00);
        do_write(11'h400, 8'hFF);
        check("R3 old value after switch", pad_out, 8'h00);
        do_write(11'h3FC, 8'hF0);
        check("R3 rewrite after switch", pad_out, 8'hF0);
        do_read(11'h3FC, rd);
        check("R5 output pins read back", rd, 8'hF0);

        // R8: strobe low
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b1; bus_addr = 11'h3FC; bus_wdata = 8'h0F;
        @(negedge clk);
        bus_addr = 11'h400; bus_wdata = 8'h00;
        @(negedge clk);
        bus_we = 1'b0;
        check("R8 pad_out", pad_out, 8'hF0);
        check("R8 pad_oe", pad_oe, 8'hFF);

        // R6: synchronizer latency
        do_write(11'h400, 8'h00);
        do_read(11'h3FC, rd);
        check("R6 before change", rd, 8'hA5);
        pad_in = 8'h3C;
        @(posedge clk); #1;
        check("R6 one edge", bus_rdata, 8'hA5);
        @(posedge clk); #1;
        check("R6 two edges", bus_rdata, 8'h3C);

        // R1: reset in mid-run
        do_write(11'h400, 8'hFF);
        do_write(11'h3FC, 8'h5A);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 pad_oe after reset", pad_oe, 8'h00);
        check("R1 pad_out after reset", pad_out, 8'h00);
        do_read(11'h3FC, rd);
        check("R1 sync cleared", rd, 8'h00);
        do_read(11'h400, rd);
        check("R1 direction cleared", rd, 8'h00);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule